// File: doc/BRIEF.md
# Ultra DMA device-side data-in burst start sequencer

This block runs the device end of the opening handshake of an Ultra DMA data-in burst. A local source hands it the first word over a ready/valid port. The sequencer then raises its burst request toward the host and waits for the host's acknowledge. From that point it counts clock cycles against two programmable minimum waits: one before it may take the strobe line, and one before it may drive the data bus. When it takes the strobe line, it drives it high first.

The data bus is enabled only when three conditions hold: the data wait has elapsed, the host has withdrawn its halt request, and the host has signalled that it is ready to receive. One cycle after the bus is enabled, the strobe falls for the first time, which transfers the word. The burst request is withdrawn in that same cycle. The strobe and the bus stay driven until the host withdraws its acknowledge. The three host lines each pass through two-flop synchronizers. Strobing of later words, pausing, termination and CRC are handled elsewhere.

The controller has six states. IDLE waits for a word. REQUEST raises the request. ARMED counts the strobe wait. STROBE_HIGH holds the strobe high and checks the data conditions. DATA_SETUP drives the word under a high strobe. TRANSFER holds the lowered strobe. The transitions are as follows:
- IDLE to REQUEST on an accepted word.
- REQUEST to ARMED on acknowledge.
- ARMED to STROBE_HIGH when the strobe wait is reached.
- STROBE_HIGH to DATA_SETUP when the data conditions hold.
- DATA_SETUP to TRANSFER unconditionally.
- TRANSFER to IDLE when the acknowledge is withdrawn.
- ARMED, STROBE_HIGH or DATA_SETUP back to REQUEST when the acknowledge is withdrawn early.

Top module: `udma_burst_start`

## Requirements
- R1: After reset, the request, the strobe enable and the bus enable are low, the strobe and the bus data are zero, and the word port is ready.
- R2: A word is accepted only in IDLE while the synchronized acknowledge is withdrawn (the acknowledge input is active low, so withdrawn means high). The request goes high in the cycle after the accepting edge. While the acknowledge is held asserted in IDLE, the port stays not ready and no request is raised.
- R3: The request stays high from acceptance until the first falling edge of the strobe, and it goes low in the same cycle that the strobe first falls.
- R4: The strobe enable rises exactly STROBE_WAIT+4 clock edges after the acknowledge input falls. This counts two synchronizer stages, one state register and STROBE_WAIT+1 cycles in ARMED.
- R5: When the strobe line is first taken, it is driven high (value 1).
- R6: The bus enable rises at edge max(k+STROBE_WAIT+4, k+DATA_WAIT+3, h+2)+1. Here k is the edge count at which the acknowledge fell, and h is the edge count at which halt went low and the ready input went low (active low ready), whichever is later. The bus is never enabled before the strobe is enabled.
- R7: While the bus is enabled, it carries the accepted word and does not change. The strobe falls exactly one cycle after the bus enable rises.
- R8: Once taken, the strobe is held until the synchronized acknowledge is withdrawn. The strobe and the bus are released three edges after the acknowledge input rises, with the request low and the word port ready again.
- R9: If the acknowledge is withdrawn before the first strobe fall, the strobe and the bus are released three edges later, the request stays high, the word is kept, and a new acknowledge restarts both waits from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_strobe_wait_i | input | CW | Minimum cycles before the strobe may be taken |
| cfg_data_wait_i | input | CW | Minimum cycles before the bus may be driven |
| word_valid_i | input | 1 | First word is offered |
| word_data_i | input | DW | First word |
| word_ready_o | output | 1 | Word is accepted this cycle when valid |
| host_ack_n_i | input | 1 | Host acknowledge, active low |
| host_halt_i | input | 1 | Host halt request, active high |
| host_ready_n_i | input | 1 | Host ready to receive, active low |
| burst_req_o | output | 1 | Burst request to host |
| strobe_o | output | 1 | Strobe level |
| strobe_oe_o | output | 1 | Strobe drive enable |
| bus_data_o | output | DW | Data bus value |
| bus_oe_o | output | 1 | Data bus drive enable |

## Verification
The assertions assume that the host follows the handshake order. The acknowledge is withdrawn before a word is offered or returns high before the next one. Halt and ready are set to their blocking levels before the acknowledge falls. Both configuration waits stay constant while a burst is open. The stimulus changes the configuration only between bursts, and it always restores halt high and ready high after each release. The one deliberate departure is an early withdrawal of the acknowledge before any data moves, which R9 defines as legal.

// File: rtl/udma_start_pkg.sv
package udma_start_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQUEST,
        ST_ARMED,
        ST_STROBE_HIGH,
        ST_DATA_SETUP,
        ST_TRANSFER
    } start_state_e;

    localparam int unsigned NUM_WAITS = 2;
    localparam int unsigned WAIT_STROBE = 0;
    localparam int unsigned WAIT_DATA = 1;
    localparam int unsigned HOST_LINES = 3;

endpackage

// File: rtl/udma_start_sync.sv
module udma_start_sync #(
    parameter int unsigned W = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] stage_q [STAGES];

    genvar gi;
    generate
        for (gi = 0; gi < STAGES; gi++) begin : g_stage
            if (gi == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[gi] <= RST_VAL;
                    else        stage_q[gi] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[gi] <= RST_VAL;
                    else        stage_q[gi] <= stage_q[gi-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/udma_start_timer.sv
module udma_start_timer #(
    parameter int unsigned CW = 6,
    parameter int unsigned NLIM = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [NLIM*CW-1:0] limits_i,
    output logic [NLIM-1:0]  reached_o
);

    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] elapsed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed_q <= '0;
        end else if (!run_i) begin
            elapsed_q <= '0;
        end else if (elapsed_q != CNT_MAX) begin
            elapsed_q <= elapsed_q + 1'b1;
        end
    end

    genvar li;
    generate
        for (li = 0; li < NLIM; li++) begin : g_limit
            assign reached_o[li] = (elapsed_q >= limits_i[li*CW +: CW]);
        end
    endgenerate

endmodule

// File: rtl/udma_start_fsm.sv
module udma_start_fsm
    import udma_start_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          word_valid_i,
    input  logic [DW-1:0] word_data_i,
    output logic          word_ready_o,
    input  logic          ack_n_s_i,
    input  logic          halt_s_i,
    input  logic          ready_n_s_i,
    input  logic          strobe_reached_i,
    input  logic          data_reached_i,
    output logic          timer_run_o,
    output logic          burst_req_o,
    output logic          strobe_o,
    output logic          strobe_oe_o,
    output logic [DW-1:0] bus_data_o,
    output logic          bus_oe_o
);

    start_state_e state_q, state_d;
    logic [DW-1:0] word_q;
    logic          accept;
    logic          host_open;

    assign accept    = word_valid_i && word_ready_o;
    assign host_open = !halt_s_i && !ready_n_s_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (word_valid_i && ack_n_s_i) state_d = ST_REQUEST;
            end
            ST_REQUEST: begin
                if (!ack_n_s_i) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (ack_n_s_i)             state_d = ST_REQUEST;
                else if (strobe_reached_i) state_d = ST_STROBE_HIGH;
            end
            ST_STROBE_HIGH: begin
                if (ack_n_s_i)                        state_d = ST_REQUEST;
                else if (data_reached_i && host_open) state_d = ST_DATA_SETUP;
            end
            ST_DATA_SETUP: begin
                if (ack_n_s_i) state_d = ST_REQUEST;
                else           state_d = ST_TRANSFER;
            end
            ST_TRANSFER: begin
                if (ack_n_s_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      word_q <= '0;
        else if (accept) word_q <= word_data_i;
    end

    always_comb begin
        word_ready_o = 1'b0;
        burst_req_o  = 1'b0;
        strobe_o     = 1'b0;
        strobe_oe_o  = 1'b0;
        bus_oe_o     = 1'b0;
        timer_run_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                word_ready_o = ack_n_s_i;
            end
            ST_REQUEST: begin
                burst_req_o = 1'b1;
            end
            ST_ARMED: begin
                burst_req_o = 1'b1;
                timer_run_o = 1'b1;
            end
            ST_STROBE_HIGH: begin
                burst_req_o = 1'b1;
                timer_run_o = 1'b1;
                strobe_oe_o = 1'b1;
                strobe_o    = 1'b1;
            end
            ST_DATA_SETUP: begin
                burst_req_o = 1'b1;
                timer_run_o = 1'b1;
                strobe_oe_o = 1'b1;
                strobe_o    = 1'b1;
                bus_oe_o    = 1'b1;
            end
            ST_TRANSFER: begin
                strobe_oe_o = 1'b1;
                bus_oe_o    = 1'b1;
            end
            default: begin
                word_ready_o = 1'b0;
            end
        endcase
    end

    assign bus_data_o = bus_oe_o ? word_q : '0;

    // R2: an accepting edge raises the request
    p_accept_raises_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid_i && word_ready_o |=> burst_req_o);

    // R3: the request is withdrawn only with the strobe low and driven
    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(burst_req_o) |-> (strobe_oe_o && !strobe_o));

    // R4: strobe taken only after the strobe wait was reached
    p_strobe_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_oe_o) |-> $past(strobe_reached_i));

    // R5: first driven level of the strobe is high
    p_strobe_first_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_oe_o) |-> strobe_o);

    // R6: bus enabled only after the data wait with the host open
    p_bus_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe_o) |-> $past(data_reached_i && !halt_s_i && !ready_n_s_i && strobe_oe_o));

    // R7: bus contents stable while driven
    p_bus_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o && $past(bus_oe_o) |-> $stable(bus_data_o));

    // R8: the strobe is not released while the host still acknowledges
    p_strobe_owned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_oe_o && !ack_n_s_i |=> strobe_oe_o);

    // R9: early withdrawal keeps the request and frees the lines
    p_abort_keeps_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n_s_i && burst_req_o && timer_run_o |=> burst_req_o && !strobe_oe_o && !bus_oe_o);

endmodule

// File: rtl/udma_burst_start.sv
module udma_burst_start
    import udma_start_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned CW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cfg_strobe_wait_i,
    input  logic [CW-1:0] cfg_data_wait_i,
    input  logic          word_valid_i,
    input  logic [DW-1:0] word_data_i,
    output logic          word_ready_o,
    input  logic          host_ack_n_i,
    input  logic          host_halt_i,
    input  logic          host_ready_n_i,
    output logic          burst_req_o,
    output logic          strobe_o,
    output logic          strobe_oe_o,
    output logic [DW-1:0] bus_data_o,
    output logic          bus_oe_o
);

    logic [HOST_LINES-1:0]   host_raw;
    logic [HOST_LINES-1:0]   host_sync;
    logic [NUM_WAITS*CW-1:0] wait_limits;
    logic [NUM_WAITS-1:0]    wait_reached;
    logic                    timer_run;

    assign host_raw = {host_ready_n_i, host_halt_i, host_ack_n_i};

    udma_start_sync #(
        .W      (HOST_LINES),
        .STAGES (2),
        .RST_VAL({HOST_LINES{1'b1}})
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(host_raw),
        .sync_o (host_sync)
    );

    assign wait_limits[WAIT_STROBE*CW +: CW] = cfg_strobe_wait_i;
    assign wait_limits[WAIT_DATA*CW +: CW]   = cfg_data_wait_i;

    udma_start_timer #(
        .CW  (CW),
        .NLIM(NUM_WAITS)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (timer_run),
        .limits_i (wait_limits),
        .reached_o(wait_reached)
    );

    udma_start_fsm #(
        .DW(DW)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .word_valid_i    (word_valid_i),
        .word_data_i     (word_data_i),
        .word_ready_o    (word_ready_o),
        .ack_n_s_i       (host_sync[0]),
        .halt_s_i        (host_sync[1]),
        .ready_n_s_i     (host_sync[2]),
        .strobe_reached_i(wait_reached[WAIT_STROBE]),
        .data_reached_i  (wait_reached[WAIT_DATA]),
        .timer_run_o     (timer_run),
        .burst_req_o     (burst_req_o),
        .strobe_o        (strobe_o),
        .strobe_oe_o     (strobe_oe_o),
        .bus_data_o      (bus_data_o),
        .bus_oe_o        (bus_oe_o)
    );

endmodule

// File: tb/udma_burst_start_tb.sv
`timescale 1ns/1ps
module udma_burst_start_tb;

    localparam int DW = 16;
    localparam int CW = 6;

    localparam int EV_REQ   = 0;
    localparam int EV_STB   = 1;
    localparam int EV_DATA  = 2;
    localparam int EV_FALL  = 3;
    localparam int EV_REL   = 4;
    localparam int EV_ABORT = 5;

    typedef struct {
        int          kind;
        int          cyc;
        logic [31:0] val;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg_strobe_wait = '0;
    logic [CW-1:0] cfg_data_wait = '0;
    logic          word_valid = 1'b0;
    logic [DW-1:0] word_data = '0;
    logic          word_ready;
    logic          host_ack_n = 1'b1;
    logic          host_halt = 1'b1;
    logic          host_ready_n = 1'b1;
    logic          burst_req;
    logic          strobe;
    logic          strobe_oe;
    logic [DW-1:0] bus_data;
    logic          bus_oe;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    bit   finished = 1'b0;
    exp_t exp_q[$];

    logic req_p = 1'b0, soe_p = 1'b0, stb_p = 1'b0, boe_p = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    udma_burst_start #(.DW(DW), .CW(CW)) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_strobe_wait_i(cfg_strobe_wait),
        .cfg_data_wait_i  (cfg_data_wait),
        .word_valid_i     (word_valid),
        .word_data_i      (word_data),
        .word_ready_o     (word_ready),
        .host_ack_n_i     (host_ack_n),
        .host_halt_i      (host_halt),
        .host_ready_n_i   (host_ready_n),
        .burst_req_o      (burst_req),
        .strobe_o         (strobe),
        .strobe_oe_o      (strobe_oe),
        .bus_data_o       (bus_data),
        .bus_oe_o         (bus_oe)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    function automatic string tag_of(input int kind);
        case (kind)
            EV_REQ:   return "R2";
            EV_STB:   return "R4";
            EV_DATA:  return "R6";
            EV_FALL:  return "R3";
            EV_REL:   return "R8";
            default:  return "R9";
        endcase
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

    task automatic push(input int kind, input int at, input logic [31:0] v);
        exp_t e;
        e.kind = kind;
        e.cyc  = at;
        e.val  = v;
        exp_q.push_back(e);
    endtask

    // monitor: pops the scoreboard as events appear at the ports
    task automatic seen(input int kind, input logic [31:0] v);
        exp_t e;
        if (exp_q.size() == 0) begin
            check(1'b0, tag_of(kind), 32'(kind), 32'hffff_ffff);
        end else begin
            e = exp_q.pop_front();
            check(e.kind == kind, tag_of(e.kind), 32'(kind), 32'(e.kind));
            check(e.cyc == cyc, tag_of(e.kind), 32'(cyc), 32'(e.cyc));
            if (kind == EV_STB)
                check(e.val == v, "R5", v, e.val);
            else if (kind == EV_DATA)
                check(e.val == v, "R7", v, e.val);
            else
                check(e.val == v, tag_of(e.kind), v, e.val);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (burst_req && !req_p) seen(EV_REQ, 32'd1);
            if (strobe_oe && !soe_p) seen(EV_STB, 32'(strobe));
            if (bus_oe && !boe_p)    seen(EV_DATA, 32'(bus_data));
            if (strobe_oe && soe_p && stb_p && !strobe) seen(EV_FALL, 32'(burst_req));
            if (!strobe_oe && soe_p) begin
                if (burst_req) seen(EV_ABORT, {30'd0, burst_req, bus_oe});
                else           seen(EV_REL, {30'd0, bus_oe, word_ready});
            end
        end
        req_p <= burst_req;
        soe_p <= strobe_oe;
        stb_p <= strobe;
        boe_p <= bus_oe;
    end

    task automatic wait_until(input int target);
        while (cyc < target) @(negedge clk);
    endtask

    task automatic offer_word(input logic [DW-1:0] w);
        @(negedge clk);
        word_valid = 1'b1;
        word_data  = w;
        push(EV_REQ, cyc + 1, 32'd1);
        @(negedge clk);
        word_valid = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // host side of a full start: acknowledge, open, hold, withdraw
    task automatic host_phase(input logic [DW-1:0] w, input int cs, input int cd, input int hd);
        int k, h, d, a;
        cfg_strobe_wait = CW'(cs);
        cfg_data_wait   = CW'(cd);
        @(negedge clk);
        k = cyc;
        host_ack_n = 1'b0;
        push(EV_STB, k + cs + 4, 32'd1);
        repeat (hd) @(negedge clk);
        h = cyc;
        host_halt    = 1'b0;
        host_ready_n = 1'b0;
        d = max3(k + cs + 4, k + cd + 3, h + 2) + 1;
        push(EV_DATA, d, 32'(w));
        push(EV_FALL, d + 1, 32'd0);
        wait_until(d + 3);
        a = cyc;
        host_ack_n = 1'b1;
        push(EV_REL, a + 3, 32'd1);
        wait_until(a + 4);
        host_halt    = 1'b1;
        host_ready_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic host_abort(input int cs, input int hold);
        int k, a;
        cfg_strobe_wait = CW'(cs);
        cfg_data_wait   = CW'(0);
        @(negedge clk);
        k = cyc;
        host_ack_n = 1'b0;
        push(EV_STB, k + cs + 4, 32'd1);
        wait_until(k + cs + 4 + hold);
        a = cyc;
        host_ack_n = 1'b1;
        push(EV_ABORT, a + 3, 32'd2);
        wait_until(a + 5);
        check(burst_req == 1'b1, "R9", 32'(burst_req), 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(burst_req == 1'b0, "R1", 32'(burst_req), 32'd0);
        check(strobe_oe == 1'b0 && strobe == 1'b0, "R1", {strobe_oe, strobe}, 32'd0);
        check(bus_oe == 1'b0 && bus_data == '0, "R1", 32'(bus_data), 32'd0);
        check(word_ready == 1'b1, "R1", 32'(word_ready), 32'd1);

        offer_word(16'hA5C3);
        host_phase(16'hA5C3, 2, 5, 0);

        offer_word(16'h1234);
        host_phase(16'h1234, 6, 1, 0);

        offer_word(16'hFFFF);
        host_phase(16'hFFFF, 0, 0, 0);

        offer_word(16'h0F0F);
        host_phase(16'h0F0F, 1, 1, 12);

        // R9: early withdrawal, then resume with the same word
        offer_word(16'hBEEF);
        host_abort(3, 2);
        host_phase(16'hBEEF, 4, 9, 0);

        // R2: acknowledge held in IDLE blocks acceptance
        begin
            int a;
            @(negedge clk);
            host_ack_n = 1'b0;
            repeat (3) @(negedge clk);
            word_valid = 1'b1;
            word_data  = 16'h5A5A;
            repeat (4) @(negedge clk);
            check(word_ready == 1'b0, "R2", 32'(word_ready), 32'd0);
            check(burst_req == 1'b0, "R2", 32'(burst_req), 32'd0);
            a = cyc;
            host_ack_n = 1'b1;
            push(EV_REQ, a + 3, 32'd1);
            wait_until(a + 3);
            word_valid = 1'b0;
            repeat (2) @(negedge clk);
            host_phase(16'h5A5A, 2, 2, 3);
        end

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R8", 32'(exp_q.size()), 32'd0);
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule